// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns two external phase signals into a position count. Both signals pass through a two-flop synchronizer and a stability filter with a programmable length. Each can then be inverted on its own, and edge detection comes after the inversion. Two encodings are supported. In quadrature mode, every edge of either phase is decoded (x4 resolution), and the order in which the phases change gives the direction. In count-and-direction mode, one phase supplies count pulses and the other sets the direction.

The counter moves only between a programmable lower bound and a programmable upper bound. A step past either bound wraps to the opposite bound. Each wrap sets a sticky overflow flag and records whether it happened at the top or at the bottom. A direction bit shows which way the most recent step went. The decoder enable is write-locked: it changes only while a separate unlock bit is set. A small word-addressed register port configures the block and reads back its state.

Top module: `qdec_counter`

Register map (word address on `reg_addr`). Address 0 is control: bit 0 is the decoder enable, bit 1 inverts phase A, bit 2 inverts phase B, bit 3 selects the mode (0 = quadrature, 1 = count-and-direction), bit 4 is the unlock bit, bits 11:8 hold the filter length N, and the other bits are plain storage. Address 1 is the lower bound. Address 2 is the upper bound. Address 3 is status: bit 0 is the overflow flag, bit 1 is the wrap side (1 = top, 0 = bottom), and bit 2 is the direction (1 = up). Address 4 is the count, read-only.

## Requirements
- R1: After reset, the count, the lower bound, control and the overflow flag and wrap side are 0. The upper bound is all ones and the direction bit is 1.
- R2: In quadrature mode with the decoder enabled, each single-phase change steps the count by one. The count goes up for the transitions AB 00→10→11→01→00 (phase A leads) and down for the reverse order.
- R3: In quadrature mode, a change on both phases between two filtered samples leaves the count unchanged.
- R4: In count-and-direction mode, each rising edge of phase A (after inversion) steps the count up when phase B is 1 and down when phase B is 0. Falling edges of A and changes on B do not count.
- R5: Each phase's inversion bit is applied before edge detection. Setting the inversion bit for A turns a falling pin edge into a counted edge, and toggling the bit while the pin is high produces a falling edge that does not count.
- R6: A step up from the upper bound loads the lower bound, sets the overflow flag and sets the wrap side to 1.
- R7: A step down from the lower bound loads the upper bound, sets the overflow flag and clears the wrap side to 0.
- R8: The direction bit takes the direction of each counted step.
- R9: A control write changes the enable bit only if the stored unlock bit is 1 at the time of the write. The other control bits are written in every case.
- R10: The overflow flag stays set until a status write with bit 0 = 0 follows a status read that returned the flag as 1. Such a write without that earlier read leaves the flag set.
- R11: An overflow in the same cycle as a valid clear leaves the flag set.
- R12: While the decoder is disabled, the count holds. Writing the lower bound, or pulsing `cnt_init`, loads the count with the lower bound.
- R13: A filtered phase takes a new level only after N+1 consecutive synchronized samples at that level. With N = 3, a 3-cycle pulse is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a | input | 1 | Phase A pin, asynchronous |
| phase_b | input | 1 | Phase B pin, asynchronous |
| cnt_init | input | 1 | Strobe that loads the count with the lower bound |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the flag clear) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data, combinational from `reg_addr` |

## Verification
The hardest case to reach is an overflow that lands in the exact cycle of an armed flag clear. It needs a flag that has already been read as 1, plus a pin edge whose count arrives on the same edge as the clearing write. The bench counts the fixed latency of synchronizer, filter and counter register from a pin change (four rising edges with N = 0) and raises the status write so that it is sampled on that fourth edge. The filter boundary is reached by holding a pin pulse for exactly N synchronized cycles, one short of acceptance, so that it must not count.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_MINB  = 3'd1;
  localparam logic [2:0] RA_MAXB  = 3'd2;
  localparam logic [2:0] RA_STAT  = 3'd3;
  localparam logic [2:0] RA_COUNT = 3'd4;

  localparam int CB_EN      = 0;
  localparam int CB_POLA    = 1;
  localparam int CB_POLB    = 2;
  localparam int CB_MODE    = 3;
  localparam int CB_UNLOCK  = 4;
  localparam int CB_FLT_LSB = 8;

  // Quadrature step from previous {a,b} to current {a,b}: returns {valid, up}.
  function automatic logic [1:0] quad_step(input logic [1:0] prev, input logic [1:0] cur);
    logic [1:0] r;
    case ({prev, cur})
      4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: r = 2'b11;
      4'b10_00, 4'b11_10, 4'b01_11, 4'b00_01: r = 2'b10;
      default:                                r = 2'b00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/qdec_sync_filter.sv
module qdec_sync_filter #(
  parameter int FLT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [FLT_W-1:0] filt_len,
  output logic             dout
);
  logic             s1_q, s2_q;
  logic [FLT_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
    end
  end

  // New level accepted after filt_len+1 consecutive samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= 1'b0;
      run_q <= '0;
    end else if (s2_q != dout) begin
      if (run_q >= filt_len) begin
        dout  <= s2_q;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end else begin
      run_q <= '0;
    end
  end
endmodule

// File: rtl/qdec_step_decode.sv
module qdec_step_decode
  import qdec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_filt,
  input  logic b_filt,
  input  logic pol_a,
  input  logic pol_b,
  input  logic mode_cd,
  output logic step_valid,
  output logic step_up
);
  logic       a_p, b_p;
  logic [1:0] prev_q;
  logic [1:0] qs;

  assign a_p = a_filt ^ pol_a;
  assign b_p = b_filt ^ pol_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b00;
    else        prev_q <= {a_p, b_p};
  end

  assign qs = quad_step(prev_q, {a_p, b_p});

  always_comb begin
    if (mode_cd) begin
      step_valid = a_p & ~prev_q[1];
      step_up    = b_p;
    end else begin
      step_valid = qs[1];
      step_up    = qs[0];
    end
  end
endmodule

// File: rtl/qdec_count_core.sv
module qdec_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             step_valid,
  input  logic             step_up,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] min_b,
  input  logic [CNT_W-1:0] max_b,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             ovf_top,
  output logic             dir_up,
  output logic             wrap_evt
);
  // Returns {wrapped, next value}.
  function automatic logic [CNT_W:0] next_pos(
    input logic [CNT_W-1:0] cur, input logic up,
    input logic [CNT_W-1:0] lo,  input logic [CNT_W-1:0] hi);
    logic [CNT_W:0] r;
    if (up) r = (cur >= hi) ? {1'b1, lo} : {1'b0, cur + 1'b1};
    else    r = (cur <= lo) ? {1'b1, hi} : {1'b0, cur - 1'b1};
    return r;
  endfunction

  logic           advance;
  logic [CNT_W:0] nxt;

  assign advance  = enable & step_valid & ~load;
  assign nxt      = next_pos(count, step_up, min_b, max_b);
  assign wrap_evt = advance & nxt[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      ovf_flag <= 1'b0;
      ovf_top  <= 1'b0;
      dir_up   <= 1'b1;
    end else begin
      if (load)         count <= load_val;
      else if (advance) count <= nxt[CNT_W-1:0];
      if (advance) dir_up <= step_up;
      if (wrap_evt) begin
        ovf_flag <= 1'b1;
        ovf_top  <= step_up;
      end else if (ovf_clr) begin
        ovf_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
  import qdec_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int FLT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             cnt_init,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata
);
  localparam int FLT_HI = CB_FLT_LSB + FLT_W - 1;

  logic [CNT_W-1:0] ctrl_q, min_q, max_q, count;
  logic             armed_q;
  logic             enable, unlock, mode_cd, pol_a, pol_b;
  logic [FLT_W-1:0] filt_len;
  logic [1:0]       filt;
  logic [1:0]       pins;
  logic             step_valid, step_up, wrap_evt;
  logic             ovf_flag, ovf_top, dir_up;
  logic             ctrl_wr, min_wr, max_wr, stat_wr, stat_rd;
  logic             load, ovf_clr, en_next;
  logic [CNT_W-1:0] load_val;

  assign enable   = ctrl_q[CB_EN];
  assign pol_a    = ctrl_q[CB_POLA];
  assign pol_b    = ctrl_q[CB_POLB];
  assign mode_cd  = ctrl_q[CB_MODE];
  assign unlock   = ctrl_q[CB_UNLOCK];
  assign filt_len = ctrl_q[FLT_HI:CB_FLT_LSB];

  assign ctrl_wr = reg_wr && reg_addr == RA_CTRL;
  assign min_wr  = reg_wr && reg_addr == RA_MINB;
  assign max_wr  = reg_wr && reg_addr == RA_MAXB;
  assign stat_wr = reg_wr && reg_addr == RA_STAT;
  assign stat_rd = reg_rd && reg_addr == RA_STAT;

  assign en_next  = unlock ? reg_wdata[CB_EN] : enable;
  assign load     = min_wr | cnt_init;
  assign load_val = min_wr ? reg_wdata : min_q;
  assign ovf_clr  = stat_wr & armed_q & ~reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      min_q   <= '0;
      max_q   <= '1;
      armed_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q        <= reg_wdata;
        ctrl_q[CB_EN] <= en_next;
      end
      if (min_wr) min_q <= reg_wdata;
      if (max_wr) max_q <= reg_wdata;
      if (stat_wr)      armed_q <= 1'b0;
      else if (stat_rd) armed_q <= ovf_flag;
    end
  end

  assign pins = {phase_a, phase_b};

  for (genvar g = 0; g < 2; g++) begin : g_phase
    qdec_sync_filter #(.FLT_W(FLT_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .din(pins[g]),
      .filt_len(filt_len), .dout(filt[g]));
  end

  qdec_step_decode u_dec (
    .clk(clk), .rst_n(rst_n), .a_filt(filt[1]), .b_filt(filt[0]),
    .pol_a(pol_a), .pol_b(pol_b), .mode_cd(mode_cd),
    .step_valid(step_valid), .step_up(step_up));

  qdec_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .step_valid(step_valid), .step_up(step_up),
    .load(load), .load_val(load_val), .min_b(min_q), .max_b(max_q),
    .ovf_clr(ovf_clr), .count(count), .ovf_flag(ovf_flag),
    .ovf_top(ovf_top), .dir_up(dir_up), .wrap_evt(wrap_evt));

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:  reg_rdata = ctrl_q;
      RA_MINB:  reg_rdata = min_q;
      RA_MAXB:  reg_rdata = max_q;
      RA_STAT:  reg_rdata[2:0] = {dir_up, ovf_top, ovf_flag};
      RA_COUNT: reg_rdata = count;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/qdec_counter_chk.sv
module qdec_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             unlock,
  input logic             ctrl_wr,
  input logic             step_valid,
  input logic             step_up,
  input logic             load,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] min_b,
  input logic [CNT_W-1:0] max_b,
  input logic             ovf_flag,
  input logic             ovf_top,
  input logic             dir_up,
  input logic             ovf_clr
);
  a_r6_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    enable && step_valid && step_up && !load && count >= max_b
    |=> count == $past(min_b) && ovf_flag && ovf_top);

  a_r7_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    enable && step_valid && !step_up && !load && count <= min_b
    |=> count == $past(max_b) && ovf_flag && !ovf_top);

  a_r8_dir_follows: assert property (@(posedge clk) disable iff (!rst_n)
    enable && step_valid && !load |=> dir_up == $past(step_up));

  a_r9_enable_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !unlock |=> enable == $past(enable));

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag);

  a_r12_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !load |=> $stable(count));
endmodule

bind qdec_counter qdec_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .unlock(unlock),
  .ctrl_wr(ctrl_wr), .step_valid(step_valid), .step_up(step_up),
  .load(load), .count(count), .min_b(min_q), .max_b(max_q),
  .ovf_flag(ovf_flag), .ovf_top(ovf_top), .dir_up(dir_up),
  .ovf_clr(ovf_clr));

// File: tb/qdec_counter_tb.sv
module qdec_counter_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 11;
  // {phase_a, phase_b, expected count} in quadrature mode, starting at AB=00, count 100
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'd101}, {1'b1, 1'b1, 16'd102}, {1'b0, 1'b1, 16'd103},
    {1'b0, 1'b0, 16'd104}, {1'b0, 1'b1, 16'd103}, {1'b1, 1'b1, 16'd102},
    {1'b1, 1'b0, 16'd101}, {1'b0, 1'b0, 16'd100}, {1'b1, 1'b1, 16'd100},
    {1'b0, 1'b0, 16'd100}, {1'b1, 1'b0, 16'd101}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_a = 1'b0, phase_b = 1'b0, cnt_init = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  int          n_chk = 0, n_fail = 0;
  logic [15:0] d;

  always #(CLK_P/2) clk = ~clk;

  qdec_counter u_dut (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .cnt_init(cnt_init), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic pulse_a();
    @(negedge clk); phase_a = 1'b1; settle();
    phase_a = 1'b0; settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd4, d); check("R1 count", d, 16'h0000);
    rd(3'd3, d); check("R1 status", d, 16'h0004);
    rd(3'd0, d); check("R1 ctrl", d, 16'h0000);
    rd(3'd2, d); check("R1 max", d, 16'hFFFF);
    rd(3'd1, d); check("R1 min", d, 16'h0000);
    // R9 write-locked enable
    wr(3'd0, 16'h0001); rd(3'd0, d); check("R9 locked", d, 16'h0000);
    wr(3'd0, 16'h0010); wr(3'd0, 16'h0011); rd(3'd0, d); check("R9 unlocked", d, 16'h0011);
    wr(3'd0, 16'h0001); wr(3'd0, 16'h0000); rd(3'd0, d); check("R9 relocked", d, 16'h0001);
    wr(3'd0, 16'h0010); rd(3'd0, d); check("R9 en kept", d, 16'h0011);
    wr(3'd0, 16'h0011);
    // R12 min write loads count
    wr(3'd1, 16'd100); rd(3'd4, d); check("R12 min load", d, 16'd100);
    // R2 / R3 quadrature table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); phase_a = VEC[i][17]; phase_b = VEC[i][16];
      settle();
      rd(3'd4, d); check($sformatf("R2/R3 vec %0d", i), d, VEC[i][15:0]);
    end
    rd(3'd3, d); check("R8 dir up", d, 16'h0004);
    @(negedge clk); phase_a = 1'b0; settle();
    rd(3'd3, d); check("R8 dir down", d, 16'h0000);
    rd(3'd4, d); check("R2 dec", d, 16'd100);
    @(negedge clk); phase_a = 1'b1; settle();
    // R12 disabled hold, init strobe
    wr(3'd0, 16'h0010);
    @(negedge clk); phase_a = 1'b0; settle();
    rd(3'd4, d); check("R12 hold", d, 16'd101);
    @(negedge clk); cnt_init = 1'b1; @(negedge clk); cnt_init = 1'b0;
    rd(3'd4, d); check("R12 init", d, 16'd100);
    // R4 count-and-direction
    wr(3'd0, 16'h0019);
    @(negedge clk); phase_b = 1'b1; settle();
    rd(3'd4, d); check("R4 b ignored", d, 16'd100);
    @(negedge clk); phase_a = 1'b1; settle();
    rd(3'd4, d); check("R4 up", d, 16'd101);
    @(negedge clk); phase_a = 1'b0; settle();
    rd(3'd4, d); check("R4 fall", d, 16'd101);
    @(negedge clk); phase_b = 1'b0; settle();
    @(negedge clk); phase_a = 1'b1; settle();
    rd(3'd4, d); check("R4 down", d, 16'd100);
    // R5 polarity before edge detection
    @(negedge clk); phase_b = 1'b1; settle();
    wr(3'd0, 16'h001B); settle();
    rd(3'd4, d); check("R5 pol toggle", d, 16'd100);
    @(negedge clk); phase_a = 1'b0; settle();
    rd(3'd4, d); check("R5 inverted edge", d, 16'd101);
    wr(3'd0, 16'h0019); settle();
    // R6 / R7 wrap
    wr(3'd2, 16'd103); wr(3'd1, 16'd100);
    @(negedge clk); phase_b = 1'b0; settle();
    pulse_a();
    rd(3'd4, d); check("R7 wrap to max", d, 16'd103);
    rd(3'd3, d); check("R7 status", d, 16'h0001);
    @(negedge clk); phase_b = 1'b1; settle();
    pulse_a();
    rd(3'd4, d); check("R6 wrap to min", d, 16'd100);
    rd(3'd3, d); check("R6 status", d, 16'h0007);
    // R10 clear after read
    wr(3'd3, 16'h0000);
    rd(3'd3, d); check("R10 cleared", d, 16'h0006);
    @(negedge clk); phase_b = 1'b0; settle();
    pulse_a();
    wr(3'd3, 16'h0000);
    rd(3'd3, d); check("R10 no-read clear ignored", d, 16'h0001);
    wr(3'd3, 16'h0000);
    rd(3'd3, d); check("R10 clear", d, 16'h0000);
    // R11 overflow wins over clear in the same cycle
    @(negedge clk); phase_b = 1'b1; settle();
    pulse_a();
    rd(3'd3, d); check("R11 armed read", d, 16'h0007);
    @(negedge clk); phase_b = 1'b0; settle();
    @(negedge clk); phase_a = 1'b1;
    repeat (3) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 16'h0000;
    @(negedge clk); reg_wr = 1'b0;
    rd(3'd3, d); check("R11 flag kept", d, 16'h0001);
    rd(3'd4, d); check("R11 count", d, 16'd103);
    @(negedge clk); phase_a = 1'b0; settle();
    // R13 filter length 3
    wr(3'd0, 16'h0319); settle();
    @(negedge clk); phase_a = 1'b1;
    repeat (3) @(negedge clk); phase_a = 1'b0; settle();
    rd(3'd4, d); check("R13 short pulse", d, 16'd103);
    @(negedge clk); phase_a = 1'b1; settle();
    rd(3'd4, d); check("R13 long pulse", d, 16'd102);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule